// File: doc/BRIEF.md
# Numeric Feature Binarizing Encoder

This block turns a stream of 16-bit unsigned tabular feature values into the flat bit vector that a small combinational classifier reads, one bit per classifier input. Each arriving value is placed in a bucket, and the bucket number is written as a short code word. The bucket comes either from a uniform split of the feature's range, set by a per-feature offset and a power-of-two bucket width, or from a set of sorted per-feature thresholds loaded beforehand. The code word is plain binary, Gray or one-hot, and each word is `BITS` bits wide.

Code words are stored in a local input buffer of `NUM_FEAT * BITS` bits, with one fixed slot per feature. Features may arrive in any order. After every feature has been written at least once since the last strobe, the block raises a one-cycle full strobe. During that cycle it refuses new input, so the classifier sees a stable word. A small output register holds the classifier's prediction, `PRED_W` bits wide, which is 1 for a two-class problem.

Top module: `feat_binarizer`

## Requirements
- R1: While reset is active and in the first cycle after it: `enc_word` is all zero, `enc_full` is low, `in_ready` is high and `pred_word` is zero.
- R2: With `cfg_mode`=0 (uniform split), the bucket for value x of feature f is 0 when x < min[f]. Otherwise it is (x − min[f]) >> shift[f], saturated to the last bucket.
- R3: With `cfg_mode`=1 (threshold split), the bucket is the number of the feature's first (bucket count − 1) thresholds that x is greater than or equal to. Thresholds are loaded in ascending order.
- R4: `cfg_code` selects the code word. 0 gives binary (the bucket number). 1 gives Gray, which is bucket ^ (bucket >> 1). 2 or 3 gives one-hot, with only bit `bucket` set. One-hot has `BITS` buckets; binary and Gray have 2^`BITS`.
- R5: An accepted value for feature f updates `enc_word[f*BITS +: BITS]` at the next clock edge. All other slots keep their contents.
- R6: `enc_full` is high for exactly one cycle. That is the cycle after the acceptance that completes the set of all features written since the previous strobe. Writing one feature twice does not complete the set.
- R7: `in_ready` is low while `enc_full` is high. A value presented in that cycle is dropped and leaves `enc_word` unchanged.
- R8: A configuration write with `cfg_we` high targets feature `cfg_feat`. `cfg_sel` 0 loads min, 1 loads shift (the low bits of `cfg_data`), and 2+k loads threshold k.
- R9: When `pred_we` is high, `pred_in` is stored and shows on `pred_word` in the next cycle. At other times `pred_word` holds its value.
- R10: Both `BITS`=2 and `BITS`=4 give the behaviour of R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_feat | input | IDX_W | Feature the configuration write targets |
| cfg_sel | input | SEL_W | 0 min, 1 shift, 2+k threshold k |
| cfg_data | input | FEAT_W | Configuration value |
| cfg_mode | input | 1 | 0 uniform split, 1 threshold split |
| cfg_code | input | 2 | 0 binary, 1 Gray, 2/3 one-hot |
| in_valid | input | 1 | Feature value present |
| in_ready | output | 1 | Block accepts a value this cycle |
| in_feat | input | IDX_W | Feature index of the value |
| in_data | input | FEAT_W | Unsigned feature value |
| enc_word | output | NUM_FEAT*BITS | Packed classifier input buffer |
| enc_full | output | 1 | One-cycle strobe: buffer complete |
| pred_we | input | 1 | Prediction write enable |
| pred_in | input | PRED_W | Prediction from the classifier |
| pred_word | output | PRED_W | Prediction output buffer |

## Verification
Bucketing and coding are combinational and feed a single register stage. The slot for an accepted value therefore shows on `enc_word` one cycle after its acceptance edge, and `enc_full` rises in that same cycle after the edge that accepts the last missing feature. The bench drives inputs on falling edges and checks the buffer, the strobe and `in_ready` on the falling edge after the final acceptance. It checks the strobe's fall and any dropped value one falling edge later. Predictions are checked one falling edge after the write, and again a cycle later to confirm they hold. Two instances, 2 and 4 bits per feature, receive the same stream, and every frame is compared against a reference model computed arithmetically for all modes and codes, including the exact bucket edges.

// File: rtl/feat_binarizer.sv
module feat_binarizer #(
  parameter int NUM_FEAT = 4,
  parameter int FEAT_W   = 16,
  parameter int BITS     = 2,
  parameter int PRED_W   = 1,
  localparam int IDX_W   = (NUM_FEAT > 1) ? $clog2(NUM_FEAT) : 1,
  localparam int NTHR    = (1 << BITS) - 1,
  localparam int SEL_W   = $clog2(NTHR + 2),
  localparam int SH_W    = $clog2(FEAT_W),
  localparam int BUF_W   = NUM_FEAT * BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_feat,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [FEAT_W-1:0] cfg_data,
  input  logic              cfg_mode,
  input  logic [1:0]        cfg_code,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_feat,
  input  logic [FEAT_W-1:0] in_data,
  output logic [BUF_W-1:0]  enc_word,
  output logic              enc_full,
  input  logic              pred_we,
  input  logic [PRED_W-1:0] pred_in,
  output logic [PRED_W-1:0] pred_word
);

  logic [FEAT_W-1:0] min_q [NUM_FEAT];
  logic [SH_W-1:0]   sh_q  [NUM_FEAT];
  logic [FEAT_W-1:0] thr_q [NUM_FEAT][NTHR];
  logic [BITS-1:0]   slot_q [NUM_FEAT];
  logic [NUM_FEAT-1:0] seen_q, seen_n;
  logic full_q;
  logic [PRED_W-1:0] pred_q;

  logic accept, onehot;
  logic [BITS-1:0] last_bkt, eq_bkt, th_bkt, bkt, code_w;
  logic [FEAT_W-1:0] scaled;

  assign onehot   = cfg_code[1];
  assign last_bkt = onehot ? BITS'(BITS - 1) : {BITS{1'b1}};
  assign in_ready = !full_q;
  assign accept   = in_valid && in_ready && ({1'b0, in_feat} < (IDX_W+1)'(NUM_FEAT));
  assign scaled   = (in_data - min_q[in_feat]) >> sh_q[in_feat];

  always_comb begin
    if (in_data < min_q[in_feat])            eq_bkt = '0;
    else if (scaled > FEAT_W'(last_bkt))     eq_bkt = last_bkt;
    else                                     eq_bkt = scaled[BITS-1:0];
  end

  always_comb begin
    th_bkt = '0;
    for (int k = 0; k < NTHR; k++)
      if (BITS'(k) < last_bkt && in_data >= thr_q[in_feat][k])
        th_bkt = th_bkt + BITS'(1);
  end

  assign bkt = cfg_mode ? th_bkt : eq_bkt;

  always_comb begin
    case (cfg_code)
      2'd0:    code_w = bkt;
      2'd1:    code_w = bkt ^ (bkt >> 1);
      default: code_w = BITS'(1) << bkt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < NUM_FEAT; f++) begin
        min_q[f] <= '0;
        sh_q[f]  <= '0;
        for (int k = 0; k < NTHR; k++) thr_q[f][k] <= '1;
      end
    end else if (cfg_we) begin
      if (cfg_sel == SEL_W'(0)) min_q[cfg_feat] <= cfg_data;
      if (cfg_sel == SEL_W'(1)) sh_q[cfg_feat]  <= cfg_data[SH_W-1:0];
      for (int k = 0; k < NTHR; k++)
        if (cfg_sel == SEL_W'(k + 2)) thr_q[cfg_feat][k] <= cfg_data;
    end
  end

  assign seen_n = seen_q | (accept ? (NUM_FEAT'(1) << in_feat) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < NUM_FEAT; f++) slot_q[f] <= '0;
      seen_q <= '0;
      full_q <= 1'b0;
      pred_q <= '0;
    end else begin
      if (accept) slot_q[in_feat] <= code_w;
      full_q <= accept && (&seen_n);
      seen_q <= (accept && (&seen_n)) ? '0 : seen_n;
      if (pred_we) pred_q <= pred_in;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_FEAT; g++) begin : g_pack
      assign enc_word[g*BITS +: BITS] = slot_q[g];
    end
  endgenerate

  assign enc_full  = full_q;
  assign pred_word = pred_q;

  assert_bucket_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (bkt <= last_bkt));
  assert_onehot_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && onehot) |-> $onehot(code_w));
  assert_hold_unless_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> $stable(enc_word));
  assert_full_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enc_full |=> !enc_full);
  assert_full_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enc_full |-> $past(accept));
  assert_pred_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pred_we |=> (pred_word == $past(pred_in)));

endmodule

// File: tb/tb_feat_binarizer.sv
module tb_feat_binarizer;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic we2, we4, cfg_mode, in_valid, pred_we;
  logic [1:0] cfg_feat, cfg_code, in_feat;
  logic [4:0] cfg_sel;
  logic [15:0] cfg_data, in_data;
  logic [2:0] pred_in, pred2;
  logic p4;
  logic ready2, ready4, full2, full4;
  logic [7:0] word2;
  logic [15:0] word4;

  int nchk = 0, nerr = 0;
  int mins[4], shs[4], thr2[4][3], thr4[4][15];
  int frame_no = 0;

  always #(CLK_P/2) clk = ~clk;

  feat_binarizer #(.NUM_FEAT(4), .FEAT_W(16), .BITS(2), .PRED_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(we2), .cfg_feat(cfg_feat), .cfg_sel(cfg_sel[2:0]),
    .cfg_data(cfg_data), .cfg_mode(cfg_mode), .cfg_code(cfg_code), .in_valid(in_valid),
    .in_ready(ready2), .in_feat(in_feat), .in_data(in_data), .enc_word(word2),
    .enc_full(full2), .pred_we(pred_we), .pred_in(pred_in), .pred_word(pred2));

  feat_binarizer #(.NUM_FEAT(4), .FEAT_W(16), .BITS(4), .PRED_W(1)) dut_w4 (
    .clk(clk), .rst_n(rst_n), .cfg_we(we4), .cfg_feat(cfg_feat), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .cfg_mode(cfg_mode), .cfg_code(cfg_code), .in_valid(in_valid),
    .in_ready(ready4), .in_feat(in_feat), .in_data(in_data), .enc_word(word4),
    .enc_full(full4), .pred_we(1'b0), .pred_in(1'b0), .pred_word(p4));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int ref_code(int bits, int x, int f, int md, int cd, int w4);
    int nb, idx, t;
    nb = (cd >= 2) ? bits : (1 << bits);
    idx = 0;
    if (md == 0) begin
      if (x >= mins[f]) idx = (x - mins[f]) >> shs[f];
      if (idx > nb - 1) idx = nb - 1;
    end else begin
      for (int k = 0; k < nb - 1; k++) begin
        t = w4 ? thr4[f][k] : thr2[f][k];
        if (x >= t) idx++;
      end
    end
    if (cd == 0) return idx;
    if (cd == 1) return idx ^ (idx >> 1);
    return 1 << idx;
  endfunction

  function automatic longint exp_word(int w4, int xs[4], int md, int cd);
    longint r = 0;
    int bits = w4 ? 4 : 2;
    for (int f = 0; f < 4; f++)
      r = r | (longint'(ref_code(bits, xs[f], f, md, cd, w4)) << (f * bits));
    return r;
  endfunction

  task automatic wcfg(input int tgt, input int f, input int sel, input int d);
    @(negedge clk);
    we2 = (tgt != 1); we4 = (tgt != 0);
    cfg_feat = f[1:0]; cfg_sel = sel[4:0]; cfg_data = d[15:0];
    @(negedge clk);
    we2 = 1'b0; we4 = 1'b0;
  endtask

  task automatic send(input int f, input int x);
    @(negedge clk);
    in_valid = 1'b1; in_feat = f[1:0]; in_data = x[15:0];
  endtask

  task automatic frame(input int xs[4], input int md, input int cd);
    longint e2, e4;
    string tg;
    for (int i = 0; i < 4; i++) begin
      int f = (i * 3 + frame_no) % 4;
      send(f, xs[f]);
    end
    frame_no++;
    @(negedge clk);
    in_valid = 1'b0;
    e2 = exp_word(0, xs, md, cd);
    e4 = exp_word(1, xs, md, cd);
    tg = (md == 0) ? "R2 R4 R5 R8" : "R3 R4 R5 R8";
    chk(full2 == 1'b1 && full4 == 1'b1, "R6 strobe after last feature", {full2, full4}, 2'b11);
    chk(ready2 == 1'b0, "R7 ready low during strobe", ready2, 0);
    chk(word2 == e2[7:0], tg, word2, e2);
    chk(word4 == e4[15:0], "R10 four-bit codes", word4, e4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int xs[4];
    longint keep;
    rst_n = 1'b0; we2 = 0; we4 = 0; cfg_feat = 0; cfg_sel = 0; cfg_data = 0;
    cfg_mode = 0; cfg_code = 0; in_valid = 0; in_feat = 0; in_data = 0;
    pred_we = 0; pred_in = 0;
    repeat (3) @(negedge clk);
    chk(word2 == 0 && word4 == 0, "R1 buffer zero", word2, 0);
    chk(full2 == 0 && ready2 == 1 && pred2 == 0, "R1 flags", {full2, ready2, pred2}, 5'b01000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word2 == 0 && full2 == 0 && ready2 == 1 && pred2 == 0, "R1 after release",
        {word2, full2, ready2, pred2}, 5'b01000);

    for (int f = 0; f < 4; f++) begin
      mins[f] = f * 3000;
      shs[f] = 8 + f;
      for (int k = 0; k < 3; k++) thr2[f][k] = (k + 1) * (5000 + f * 3000);
      for (int k = 0; k < 15; k++) thr4[f][k] = (k + 1) * (1000 + f * 800);
      wcfg(2, f, 0, mins[f]);
      wcfg(2, f, 1, shs[f]);
      for (int k = 0; k < 3; k++) wcfg(0, f, 2 + k, thr2[f][k]);
      for (int k = 0; k < 15; k++) wcfg(1, f, 2 + k, thr4[f][k]);
    end

    for (int md = 0; md < 2; md++) begin
      for (int cd = 0; cd < 3; cd++) begin
        @(negedge clk);
        cfg_mode = md[0]; cfg_code = cd[1:0];
        for (int base = 0; base < 65536; base += 331) begin
          for (int f = 0; f < 4; f++) xs[f] = (base + f * 577 + f * f * 91) & 16'hffff;
          frame(xs, md, cd);
        end
        for (int j = 0; j <= 16; j++) begin
          for (int d = 0; d < 2; d++) begin
            for (int f = 0; f < 4; f++) begin
              int x = mins[f] + (j << shs[f]) - d;
              xs[f] = (x < 0) ? 0 : ((x > 65535) ? 65535 : x);
            end
            frame(xs, md, cd);
          end
        end
        for (int j = 0; j < 18; j++) begin
          for (int d = 0; d < 2; d++) begin
            for (int f = 0; f < 4; f++)
              xs[f] = ((j < 15) ? thr4[f][j] : thr2[f][j - 15]) - d;
            frame(xs, md, cd);
          end
        end
      end
    end

    @(negedge clk);
    cfg_mode = 1'b0; cfg_code = 2'd0;
    xs[0] = 100; xs[1] = 9000; xs[2] = 20000; xs[3] = 40000;
    send(0, xs[0]); send(1, 0); send(1, xs[1]); send(2, xs[2]);
    @(negedge clk);
    in_valid = 1'b0;
    chk(full2 == 1'b0, "R6 duplicate does not complete set", full2, 0);
    send(3, xs[3]);
    @(negedge clk);
    keep = exp_word(0, xs, 0, 0);
    chk(full2 == 1'b1, "R6 strobe after final feature", full2, 1);
    chk(word2 == keep[7:0], "R5 later write wins", word2, keep);
    in_valid = 1'b1; in_feat = 2'd0; in_data = 16'hffff;
    @(negedge clk);
    in_valid = 1'b0;
    chk(word2 == keep[7:0], "R7 value during strobe dropped", word2, keep);
    chk(full2 == 1'b0, "R6 strobe lasts one cycle", full2, 0);
    chk(ready2 == 1'b1, "R7 ready back after strobe", ready2, 1);

    @(negedge clk);
    pred_we = 1'b1; pred_in = 3'd5;
    @(negedge clk);
    pred_we = 1'b0; pred_in = 3'd2;
    chk(pred2 == 3'd5, "R9 prediction stored", pred2, 5);
    @(negedge clk);
    chk(pred2 == 3'd5, "R9 prediction held without write", pred2, 5);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule